// File: doc/BRIEF.md
# Double-Buffered Full-Duplex Serial Master

This block is a full-duplex serial-peripheral master for 8-bit frames with one holding buffer per direction. The transmit holding buffer sits in front of the outgoing shift register, and the receive holding buffer sits behind the incoming one. A host can therefore load the next byte while the current byte is still shifting. The next frame then starts on the bit clock right after the last bit of the current one, and the serial clock never pauses in between.

The host side is a strobe-driven register port. `wr_en` offers a byte. `rd_en` takes the received byte. `st_rd` marks a status read. Three flags report the state of the buffers and the link:

- `txe`: the transmit holding buffer is empty.
- `rxne`: the receive holding buffer is full.
- `bsy`: a burst is in progress.

A sticky `ovr` flag reports a received byte that was overwritten before the host read it.

The serial clock idles high. Each bit opens with a falling edge, where the master changes MOSI, and closes with a rising edge, where it samples MISO. Bits are sent most significant first. The length of each clock half is a power of two between 2 and 256 system clocks, chosen by `div_sel`.

The transfer engine is a three-state machine:

- **IDLE**: the clock is held high.
- **LEAD**: the clock is low and the current bit is driven.
- **TRAIL**: the clock is high, after MISO was sampled on entry.

The transitions are:

- **start** (IDLE→LEAD): the block is enabled and a byte is held.
- **sample** (LEAD→TRAIL): the half period has elapsed.
- **next_bit** (TRAIL→LEAD): a half period has elapsed and this was not the eighth bit.
- **chain** (TRAIL→LEAD): the eighth bit has ended, and the block is enabled with a byte held. The held byte is loaded at once.
- **finish** (TRAIL→IDLE): the eighth bit has ended and no byte is pending.

Top module: `spi_dbuf_master`

## Requirements
- R1: After reset, `txe`=1, `rxne`=0, `bsy`=0, `ovr`=0 and `sck`=1.
- R2: Each frame is 8 bits, sent MSB first. MOSI changes on the falling SCK edge and MISO is sampled on the rising edge. Each byte sent is matched by one byte received.
- R3: A write accepted while `txe`=1 clears `txe` on the next cycle. `txe` returns to 1 when the held byte moves into the shift register.
- R4: A write while `txe`=0 is ignored, and the held byte goes out unchanged.
- R5: No transfer starts while `enable`=0, even if a byte is held. `bsy` stays 0 and `sck` stays high.
- R6: When each next byte is written before the current frame ends, a burst of N frames runs with no gap. The time from the first falling SCK edge to the last rising edge is exactly (16·N−1) half periods.
- R7: `rxne` is set when a complete frame lands in the receive buffer, and `rd_data` shows that byte. A pulse on `rd_en` clears `rxne`.
- R8: `bsy` rises at the start of a burst and stays high across chained frames. It falls once, after the last frame, when no byte is pending. While `bsy`=0, `sck` is high.
- R9: A frame that completes while `rxne`=1 overwrites the buffer and sets a sticky `ovr`. `ovr` is cleared only by a status read (`st_rd`) that follows a data read (`rd_en`). A status read alone leaves it set.
- R10: One SCK half period lasts 2^(`div_sel`+1) system clocks: 2 for `div_sel`=0, up to 256 for `div_sel`=7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Allows transfers to start |
| div_sel | input | 3 | Half period = 2^(div_sel+1) clocks |
| wr_en | input | 1 | Write strobe for the transmit byte |
| wr_data | input | 8 | Byte to send |
| rd_en | input | 1 | Read strobe for the received byte |
| st_rd | input | 1 | Status-read strobe (second step of overrun clear) |
| rd_data | output | 8 | Received byte |
| txe | output | 1 | Transmit holding buffer empty |
| rxne | output | 1 | Receive holding buffer full |
| bsy | output | 1 | Burst in progress |
| ovr | output | 1 | Sticky receive overrun |
| sck | output | 1 | Serial clock, idle high |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The properties assume that the strobes are single-cycle pulses and that `div_sel` stays constant while `bsy` is high. The bench changes `div_sel` only between bursts, when the link is idle, and every strobe it drives lasts one cycle, launched on the falling system-clock edge. The bench's serial slave model changes MISO only after it sees a falling SCK edge. MISO is therefore stable for at least one system clock before each rising edge, where the master samples it.

// File: rtl/spi_dbuf_pkg.sv
package spi_dbuf_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LEAD  = 2'd1,
        ST_TRAIL = 2'd2
    } xfer_state_t;
endpackage

// File: rtl/spi_halfbit_timer.sv
module spi_halfbit_timer #(
    parameter int SEL_W = 3,
    parameter int CNT_W = (1 << SEL_W) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [SEL_W-1:0] div_sel,
    output logic             tick
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;

    // last count of a half period: 2^(div_sel+1) - 1
    assign limit = (CNT_W'(2) << div_sel) - CNT_W'(1);
    assign tick  = run && (cnt_q == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end
endmodule

// File: rtl/spi_tx_holder.sv
module spi_tx_holder #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         take,
    output logic [W-1:0] hold_data,
    output logic         full
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_data <= '0;
            full      <= 1'b0;
        end else if (take) begin
            full <= 1'b0;
        end else if (wr_en && !full) begin
            hold_data <= wr_data;
            full      <= 1'b1;
        end
    end
endmodule

// File: rtl/spi_rx_holder.sv
module spi_rx_holder #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         rd_en,
    input  logic         st_rd,
    output logic [W-1:0] rd_data,
    output logic         rxne,
    output logic         ovr
);
    logic armed_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data <= '0;
            rxne    <= 1'b0;
        end else if (push) begin
            rd_data <= push_data;
            rxne    <= 1'b1;
        end else if (rd_en) begin
            rxne <= 1'b0;
        end
    end

    // overrun: set by a push onto an unread byte; cleared by data read then status read
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovr     <= 1'b0;
            armed_q <= 1'b0;
        end else begin
            if (push && rxne && !rd_en) begin
                ovr     <= 1'b1;
                armed_q <= 1'b0;
            end else if (st_rd && armed_q) begin
                ovr     <= 1'b0;
                armed_q <= 1'b0;
            end else if (rd_en && ovr) begin
                armed_q <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
    import spi_dbuf_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         enable,
    input  logic         tick,
    input  logic         tx_full,
    input  logic [W-1:0] tx_data,
    input  logic         miso,
    output logic         take,
    output logic         push,
    output logic [W-1:0] push_data,
    output logic         run,
    output logic         busy,
    output logic         sck,
    output logic         mosi
);
    localparam int BIT_W = (W > 1) ? $clog2(W) : 1;

    xfer_state_t      state_q, state_d;
    logic [W-1:0]     tx_sh_q;
    logic [W-1:0]     rx_sh_q;
    logic [BIT_W-1:0] bit_q;
    logic             sample;
    logic             shift;
    logic             last_bit;
    logic             sck_q;

    assign last_bit = (bit_q == BIT_W'(W - 1));

    // next state and control strobes
    always_comb begin
        state_d = state_q;
        take    = 1'b0;
        push    = 1'b0;
        sample  = 1'b0;
        shift   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (enable && tx_full) begin
                    take    = 1'b1;
                    state_d = ST_LEAD;
                end
            end
            ST_LEAD: begin
                if (tick) begin
                    sample  = 1'b1;
                    state_d = ST_TRAIL;
                end
            end
            ST_TRAIL: begin
                if (tick) begin
                    if (last_bit) begin
                        push = 1'b1;
                        if (enable && tx_full) begin
                            take    = 1'b1;
                            state_d = ST_LEAD;
                        end else begin
                            state_d = ST_IDLE;
                        end
                    end else begin
                        shift   = 1'b1;
                        state_d = ST_LEAD;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // datapath and registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sh_q <= '0;
            rx_sh_q <= '0;
            bit_q   <= '0;
            sck_q   <= 1'b1;
        end else begin
            sck_q <= (state_d != ST_LEAD);
            if (take) begin
                tx_sh_q <= tx_data;
                bit_q   <= '0;
            end else if (shift) begin
                tx_sh_q <= {tx_sh_q[W-2:0], 1'b0};
                bit_q   <= bit_q + BIT_W'(1);
            end
            if (sample) begin
                rx_sh_q <= {rx_sh_q[W-2:0], miso};
            end
        end
    end

    assign push_data = rx_sh_q;
    assign run       = (state_q != ST_IDLE);
    assign busy      = run;
    assign sck       = sck_q;
    assign mosi      = tx_sh_q[W-1];
endmodule

// File: rtl/spi_dbuf_master.sv
module spi_dbuf_master #(
    parameter int DATA_W    = 8,
    parameter int DIV_SEL_W = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 enable,
    input  logic [DIV_SEL_W-1:0] div_sel,
    input  logic                 wr_en,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic                 rd_en,
    input  logic                 st_rd,
    output logic [DATA_W-1:0]    rd_data,
    output logic                 txe,
    output logic                 rxne,
    output logic                 bsy,
    output logic                 ovr,
    output logic                 sck,
    output logic                 mosi,
    input  logic                 miso
);
    localparam int CNT_W = (1 << DIV_SEL_W) + 1;

    logic              tick;
    logic              run;
    logic              take;
    logic              push;
    logic              tx_full;
    logic [DATA_W-1:0] tx_hold_data;
    logic [DATA_W-1:0] rx_word;

    spi_halfbit_timer #(.SEL_W(DIV_SEL_W), .CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(run), .div_sel(div_sel), .tick(tick)
    );

    spi_tx_holder #(.W(DATA_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .take(take), .hold_data(tx_hold_data), .full(tx_full)
    );

    spi_rx_holder #(.W(DATA_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .push(push), .push_data(rx_word),
        .rd_en(rd_en), .st_rd(st_rd), .rd_data(rd_data), .rxne(rxne), .ovr(ovr)
    );

    spi_shift_engine #(.W(DATA_W)) u_eng (
        .clk(clk), .rst_n(rst_n), .enable(enable), .tick(tick),
        .tx_full(tx_full), .tx_data(tx_hold_data), .miso(miso),
        .take(take), .push(push), .push_data(rx_word), .run(run),
        .busy(bsy), .sck(sck), .mosi(mosi)
    );

    assign txe = !tx_full;
endmodule

// File: rtl/spi_dbuf_master_chk.sv
module spi_dbuf_master_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         enable,
    input logic         wr_en,
    input logic         rd_en,
    input logic         st_rd,
    input logic         txe,
    input logic         rxne,
    input logic         bsy,
    input logic         ovr,
    input logic         sck,
    input logic [W-1:0] hold
);
    a_r3_write_clears_txe: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && txe) |=> !txe);

    a_r4_held_byte_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !txe) |=> $stable(hold));

    a_r5_no_start_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && !bsy) |=> !bsy);

    a_r7_rxne_until_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rxne && !rd_en) |=> rxne);

    a_r8_sck_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        !bsy |-> sck);

    a_r9_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr && !st_rd) |=> ovr);

    a_r9_ovr_with_rxne: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr) |-> rxne);
endmodule

bind spi_dbuf_master spi_dbuf_master_chk #(.W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .enable(enable), .wr_en(wr_en), .rd_en(rd_en),
    .st_rd(st_rd), .txe(txe), .rxne(rxne), .bsy(bsy), .ovr(ovr), .sck(sck),
    .hold(tx_hold_data)
);

// File: tb/spi_dbuf_master_tb.sv
module spi_dbuf_master_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic [2:0] div_sel = 3'd1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       rd_en = 1'b0;
    logic       st_rd = 1'b0;
    logic [7:0] rd_data;
    logic       txe, rxne, bsy, ovr, sck, mosi;
    logic       miso = 1'b1;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    spi_dbuf_master u_dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .div_sel(div_sel),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .st_rd(st_rd),
        .rd_data(rd_data), .txe(txe), .rxne(rxne), .bsy(bsy), .ovr(ovr),
        .sck(sck), .mosi(mosi), .miso(miso)
    );

    // serial-side model and edge timing, all at the falling system-clock edge
    logic [7:0] slave_q [0:7];
    logic [7:0] cap_q   [0:7];
    int   sidx, sbit, midx, mbit;
    logic [7:0] scur, mcap;
    int   cyc, first_fall, first_rise, last_rise, bsy_falls;
    bit   seen_fall, seen_rise;
    logic sck_prev = 1'b1, bsy_prev = 1'b0;

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (sck_prev && !sck) begin
            if (!seen_fall) begin first_fall = cyc; seen_fall = 1'b1; end
            if (sbit == 0) begin scur = slave_q[sidx]; sidx = sidx + 1; end
            miso = scur[7 - sbit];
            sbit = (sbit + 1) % 8;
        end
        if (!sck_prev && sck) begin
            if (!seen_rise) begin first_rise = cyc; seen_rise = 1'b1; end
            last_rise = cyc;
            mcap = {mcap[6:0], mosi};
            mbit = mbit + 1;
            if (mbit == 8) begin cap_q[midx] = mcap; midx = midx + 1; mbit = 0; end
        end
        if (bsy_prev && !bsy) bsy_falls = bsy_falls + 1;
        sck_prev = sck;
        bsy_prev = bsy;
    end

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic clear_mon();
        sidx = 0; sbit = 0; midx = 0; mbit = 0;
        seen_fall = 1'b0; seen_rise = 1'b0; bsy_falls = 0;
    endtask

    task automatic host_write(input logic [7:0] b);
        @(negedge clk); wr_en = 1'b1; wr_data = b;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic host_read(output logic [7:0] b);
        @(negedge clk); b = rd_data; rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic status_read();
        @(negedge clk); st_rd = 1'b1;
        @(negedge clk); st_rd = 1'b0;
    endtask

    task automatic wait_burst();
        while (!bsy) @(negedge clk);
        while (bsy)  @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1 txe", txe, 1);
        check("R1 rxne", rxne, 0);
        check("R1 bsy", bsy, 0);
        check("R1 ovr", ovr, 0);
        check("R1 sck", sck, 1);
    endtask

    task automatic t_single();
        logic [7:0] r;
        clear_mon();
        slave_q[0] = 8'hA1;
        @(negedge clk); wr_en = 1'b1; wr_data = 8'hF1;
        @(negedge clk); wr_en = 1'b0;
        check("R3 txe cleared by write", txe, 0);
        while (!bsy) @(negedge clk);
        check("R3 txe set on load", txe, 1);
        while (bsy) @(negedge clk);
        repeat (2) @(negedge clk);
        check("R2 mosi byte", cap_q[0], 8'hF1);
        check("R2 frames sent", midx, 1);
        check("R7 rxne set", rxne, 1);
        check("R7 rd_data", rd_data, 8'hA1);
        host_read(r);
        check("R7 rxne cleared by read", rxne, 0);
        check("R8 sck idle after burst", sck, 1);
        check("R6 single frame span", last_rise - first_fall, 15 * 4);
    endtask

    task automatic t_burst();
        logic [7:0] got [0:2];
        clear_mon();
        slave_q[0] = 8'hA1; slave_q[1] = 8'hA2; slave_q[2] = 8'hA3;
        fork
            begin
                for (int i = 0; i < 3; i++) begin
                    while (!txe) @(negedge clk);
                    wr_en = 1'b1; wr_data = 8'hF1 + 8'(i);
                    @(negedge clk); wr_en = 1'b0;
                end
            end
            begin
                for (int i = 0; i < 3; i++) begin
                    while (!rxne) @(negedge clk);
                    got[i] = rd_data; rd_en = 1'b1;
                    @(negedge clk); rd_en = 1'b0;
                end
            end
        join
        repeat (3) @(negedge clk);
        for (int i = 0; i < 3; i++) begin
            check("R2 burst mosi", cap_q[i], 8'hF1 + i);
            check("R7 burst rx", got[i], 8'hA1 + i);
        end
        check("R6 gap-free span", last_rise - first_fall, 47 * 4);
        check("R8 bsy one fall per burst", bsy_falls, 1);
        check("R9 no overrun when read in time", ovr, 0);
    endtask

    task automatic t_ignore_and_enable();
        logic [7:0] r;
        clear_mon();
        slave_q[0] = 8'h3C;
        enable = 1'b0;
        host_write(8'h5A);
        check("R4 txe low after first write", txe, 0);
        host_write(8'hC3);
        repeat (20) @(negedge clk);
        check("R5 no start while disabled", bsy, 0);
        check("R5 sck high while disabled", sck, 1);
        check("R5 no bits sent", midx, 0);
        enable = 1'b1;
        wait_burst();
        check("R4 held byte sent unchanged", cap_q[0], 8'h5A);
        check("R4 only one frame", midx, 1);
        host_read(r);
        check("R2 rx byte", r, 8'h3C);
    endtask

    task automatic t_overrun();
        logic [7:0] r;
        clear_mon();
        slave_q[0] = 8'h11; slave_q[1] = 8'h22;
        host_write(8'h01);
        host_write(8'h02);
        wait_burst();
        check("R9 ovr set", ovr, 1);
        check("R9 newest byte kept", rd_data, 8'h22);
        status_read();
        check("R9 status read alone keeps ovr", ovr, 1);
        host_read(r);
        check("R9 ovr kept after data read", ovr, 1);
        status_read();
        check("R9 ovr cleared", ovr, 0);
        check("R7 rxne cleared", rxne, 0);
    endtask

    task automatic t_divider(input logic [2:0] sel);
        logic [7:0] r;
        int half;
        half = 2 << sel;
        clear_mon();
        slave_q[0] = 8'h96;
        div_sel = sel;
        host_write(8'h69);
        wait_burst();
        check("R10 half period", first_rise - first_fall, half);
        check("R10 frame span", last_rise - first_fall, 15 * half);
        check("R2 byte at divider", cap_q[0], 8'h69);
        host_read(r);
        check("R2 rx at divider", r, 8'h96);
        div_sel = 3'd1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        cyc = 0;
        clear_mon();
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        enable = 1'b1;
        t_single();
        t_burst();
        t_ignore_and_enable();
        t_overrun();
        t_divider(3'd0);
        t_divider(3'd7);
        finish_run();
    end
endmodule